// File: doc/BRIEF.md
# Filtered External Interrupt Controller

This block takes up to 32 asynchronous input pins and turns their level changes into interrupt or DMA requests. Each pin passes through a two-stage synchronizer, then an optional glitch filter, then an edge detector. The edge detector can be set per pin to fire on rising edges, falling edges, both, or neither. A detected edge sets a sticky flag for that pin. Software clears a flag by writing 1 to its bit.

A flag becomes a pending request only when the pin's request enable bit is also set. A per-pin select bit decides where the pending request goes. With the bit at 0 the request is ORed onto the interrupt line of the pin's group. With the bit at 1 it appears on a dedicated DMA request output for that pin, and an acknowledge pulse on that pin's DMA acknowledge input clears the flag. A single-cycle 32-bit register port writes the configuration and reads it back. Reads are combinational from the address.

The glitch filter is paced by a shared prescaler. It passes a new level only after the synchronized input has held that level for a programmed number of filter ticks.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and all `irq_line` and `dma_req` outputs are low.
- R2: With bit n of the rising-enable register (offset 0x18) set, a low-to-high change on pin n sets bit n of the flag register (offset 0x00). With that bit clear, the change leaves the flag at 0.
- R3: With bit n of the falling-enable register (offset 0x20) set, a high-to-low change on pin n sets flag n. With both enables set, either change sets it. With neither set, no change sets it.
- R4: Writing to offset 0x00 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R5: A pin is pending when its flag and its bit in the request-enable register (offset 0x08) are both 1. Interrupt line k (group size G, default 8) is high when any pin from k*G to k*G+G-1 is pending with select bit 0.
- R6: With bit n of the select register (offset 0x10) at 1, a pending request on pin n drives `dma_req[n]` and not the interrupt line. A one-cycle pulse on `dma_ack[n]` clears flag n.
- R7: With bit n of the filter-enable register (offset 0x28) at 0, a pulse one clock long on pin n is detected.
- R8: With the filter on, the pin's filter limit at offset 0x30+4*n (bits [3:0]) and the prescaler at offset 0xB0 (bits [3:0]) apply. A filter tick occurs every prescaler+1 clocks. A new level passes only after it has held for limit+1 consecutive ticks, so shorter pulses set no flag.
- R9: If an edge on pin n and a write of 1 to flag n happen in the same cycle, flag n ends up set.
- R10: Configuration registers read back what was written, truncated to their field width (4 bits for the limit and the prescaler).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous external pins |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dma_ack | input | NPINS | Per-pin DMA acknowledge pulses |
| dma_req | output | NPINS | Per-pin DMA requests |
| irq_line | output | NPINS/GROUP | Grouped interrupt lines |

## Verification
Single pins are driven with isolated rising and falling transitions under each edge-enable setting. This shows that each edge type is gated by its own enable. Pulses of lengths just below and well above the filter threshold are applied, at two prescaler settings. These separate correct tick pacing and limit handling from an off-by-one error, and a one-clock pulse with the filter off confirms the bypass. Pins in different groups, with the select bit changed between interrupt and DMA, show that routing follows the group map and the select bit. A falling edge that lands in the same cycle as a clear shows that the set takes priority.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam logic [7:0] OFS_FLAG  = 8'h00;
  localparam logic [7:0] OFS_REQEN = 8'h08;
  localparam logic [7:0] OFS_RSEL  = 8'h10;
  localparam logic [7:0] OFS_RISE  = 8'h18;
  localparam logic [7:0] OFS_FALL  = 8'h20;
  localparam logic [7:0] OFS_FEN   = 8'h28;
  localparam logic [7:0] OFS_LIMIT = 8'h30;
  localparam logic [7:0] OFS_PRE   = 8'hB0;
  localparam int unsigned CW = 4;

  // sticky flag update: clears first, new events win
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  // prescaler wraps after pre+1 clocks
  function automatic logic tick_due(input logic [CW-1:0] cnt, input logic [CW-1:0] pre);
    return cnt >= pre;
  endfunction

  // filter passes the new level once limit+1 ticks have elapsed
  function automatic logic held_long_enough(input logic [CW-1:0] cnt, input logic [CW-1:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end
  assign dout = s2_q;
endmodule

// File: rtl/eirq_tick_gen.sv
module eirq_tick_gen
  import eirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pre,
  output logic          tick
);
  logic [CW-1:0] cnt_q;
  assign tick = tick_due(cnt_q, pre);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eirq_glitch_filter.sv
module eirq_glitch_filter
  import eirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  input  logic          din,
  output logic          held_q,
  output logic          lvl
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en || din == held_q) begin
      held_q <= din;
      cnt_q  <= '0;
    end else if (tick) begin
      if (held_long_enough(cnt_q, limit)) begin
        held_q <= din;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
  assign lvl = en ? held_q : din;
endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned GROUP = 8,
  localparam int unsigned NLINES = NPINS / GROUP,
  localparam int unsigned IDX_W  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [7:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  dma_ack,
  output logic [NPINS-1:0]  dma_req,
  output logic [NLINES-1:0] irq_line
);
  logic [NPINS-1:0] flag_q, reqen_q, rsel_q, rise_q, fall_q, fen_q;
  logic [CW-1:0]    limit_q [NPINS];
  logic [CW-1:0]    pre_q;

  // named internal events for the checker
  logic [NPINS-1:0] evt, clr_mask, pending, filt_q;
  logic             tick;

  logic [7:0]       lim_off;
  logic             lim_hit;
  logic [IDX_W-1:0] lim_idx;
  assign lim_off = reg_addr - OFS_LIMIT;
  assign lim_hit = (reg_addr >= OFS_LIMIT) && (int'(lim_off[7:2]) < int'(NPINS)) &&
                   (lim_off[1:0] == 2'b00);
  assign lim_idx = lim_off[2 +: IDX_W];

  eirq_tick_gen u_tick (.clk(clk), .rst_n(rst_n), .pre(pre_q), .tick(tick));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sync_lvl, flt_lvl, r_e, f_e;
    eirq_sync u_sync (.clk(clk), .rst_n(rst_n), .din(pin_in[i]), .dout(sync_lvl));
    eirq_glitch_filter u_flt (
      .clk(clk), .rst_n(rst_n), .en(fen_q[i]), .tick(tick), .limit(limit_q[i]),
      .din(sync_lvl), .held_q(filt_q[i]), .lvl(flt_lvl)
    );
    eirq_edge_det u_edge (.clk(clk), .rst_n(rst_n), .lvl(flt_lvl), .rise(r_e), .fall(f_e));
    assign evt[i] = (rise_q[i] & r_e) | (fall_q[i] & f_e);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                             limit_q[i] <= '0;
      else if (reg_we && lim_hit && lim_idx == IDX_W'(i)) limit_q[i] <= reg_wdata[CW-1:0];
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqen_q <= '0;
      rsel_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      fen_q   <= '0;
      pre_q   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_REQEN: reqen_q <= reg_wdata[NPINS-1:0];
        OFS_RSEL:  rsel_q  <= reg_wdata[NPINS-1:0];
        OFS_RISE:  rise_q  <= reg_wdata[NPINS-1:0];
        OFS_FALL:  fall_q  <= reg_wdata[NPINS-1:0];
        OFS_FEN:   fen_q   <= reg_wdata[NPINS-1:0];
        OFS_PRE:   pre_q   <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  // sticky flags
  assign clr_mask = ((reg_we && reg_addr == OFS_FLAG) ? reg_wdata[NPINS-1:0] : '0) |
                    (dma_ack & rsel_q);
  logic [31:0] flag_d;
  assign flag_d = flag_next(32'(flag_q), 32'(clr_mask), 32'(evt));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d[NPINS-1:0];
  end

  // request routing
  assign pending = flag_q & reqen_q;
  assign dma_req = pending & rsel_q;
  for (genvar k = 0; k < NLINES; k++) begin : g_line
    assign irq_line[k] = |(pending[k*GROUP +: GROUP] & ~rsel_q[k*GROUP +: GROUP]);
  end

  // read port
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_FLAG:  reg_rdata = 32'(flag_q);
      OFS_REQEN: reg_rdata = 32'(reqen_q);
      OFS_RSEL:  reg_rdata = 32'(rsel_q);
      OFS_RISE:  reg_rdata = 32'(rise_q);
      OFS_FALL:  reg_rdata = 32'(fall_q);
      OFS_FEN:   reg_rdata = 32'(fen_q);
      OFS_PRE:   reg_rdata = 32'(pre_q);
      default:   if (lim_hit) reg_rdata = 32'(limit_q[lim_idx]);
    endcase
  end
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned NLINES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  clr_mask,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  pending,
  input logic [NPINS-1:0]  fen_q,
  input logic [NPINS-1:0]  filt_q,
  input logic              tick,
  input logic [NPINS-1:0]  dma_req,
  input logic [NLINES-1:0] irq_line
);
  // R2, R9: every event is visible as a set flag one cycle later
  p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(evt)) == $past(evt)));

  // R4: a flag falls only where a clear was requested
  p_flag_falls_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~flag_q & ~$past(clr_mask)) == '0));

  // R5: no interrupt line without a pending pin
  p_line_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (irq_line == '0));

  // R6: a DMA request implies its flag is set
  p_dma_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_req & ~flag_q) == '0));

  // R8: an enabled filter only changes level on a filter tick
  p_filter_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((filt_q ^ $past(filt_q)) & $past(fen_q)) == '0) || $past(tick)));
endmodule

bind ext_irq_ctrl eirq_checker #(.NPINS(NPINS), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .clr_mask(clr_mask), .flag_q(flag_q),
  .pending(pending), .fen_q(fen_q), .filt_q(filt_q), .tick(tick),
  .dma_req(dma_req), .irq_line(irq_line)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int NP = 32;
  localparam int NL = 4;
  localparam logic [7:0] A_FLAG = 8'h00, A_REQEN = 8'h08, A_RSEL = 8'h10, A_RISE = 8'h18,
                         A_FALL = 8'h20, A_FEN = 8'h28, A_LIM = 8'h30, A_PRE = 8'hB0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [7:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] dma_ack = '0;
  logic [NP-1:0] dma_req;
  logic [NL-1:0] irq_line;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NPINS(NP), .GROUP(8)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_ack(dma_ack), .dma_req(dma_req),
    .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pin(input int p, input logic v, input int settle);
    pin_in[p] = v;
    wait_n(settle);
  endtask

  task automatic pulse(input int p, input int len, input int settle);
    pin_in[p] = 1'b1;
    wait_n(len);
    pin_in[p] = 1'b0;
    wait_n(settle);
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    foreach (A_LIST[i]) begin
      rd(A_LIST[i], v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq_line", 32'(irq_line), 32'h0);
    chk("R1 reset dma_req", 32'(dma_req), 32'h0);
  endtask
  logic [7:0] A_LIST [9] = '{A_FLAG, A_REQEN, A_RSEL, A_RISE, A_FALL, A_FEN, A_LIM, 8'h6C, A_PRE};

  task automatic t_readback_r10();
    logic [31:0] v;
    wr(A_LIM + 8'd20, 32'hFFFF_FFF7); rd(A_LIM + 8'd20, v); chk("R10 limit width", v, 32'h7);
    rd(A_LIM + 8'd24, v); chk("R10 neighbour limit untouched", v, 32'h0);
    wr(A_PRE, 32'h0000_001A); rd(A_PRE, v); chk("R10 prescaler width", v, 32'hA);
    wr(A_REQEN, 32'hA5A5_0F0F); rd(A_REQEN, v); chk("R10 enable readback", v, 32'hA5A5_0F0F);
    wr(A_LIM + 8'd20, 0); wr(A_PRE, 0); wr(A_REQEN, 0);
  endtask

  task automatic t_rise_r2();
    logic [31:0] v;
    wr(A_RISE, 32'h8);
    set_pin(3, 1'b1, 5); rd(A_FLAG, v); chk("R2 rising edge sets flag", v, 32'h8);
    wr(A_FLAG, 32'h8);
    set_pin(3, 1'b0, 5); rd(A_FLAG, v); chk("R2 falling edge ignored when only rise on", v, 32'h0);
    pulse(4, 3, 5); rd(A_FLAG, v); chk("R2 pin without enable stays clear", v, 32'h0);
    wr(A_RISE, 0);
  endtask

  task automatic t_fall_both_r3();
    logic [31:0] v;
    wr(A_FALL, 32'h20);
    set_pin(5, 1'b1, 5); rd(A_FLAG, v); chk("R3 rise ignored when only fall on", v, 32'h0);
    set_pin(5, 1'b0, 5); rd(A_FLAG, v); chk("R3 falling edge sets flag", v, 32'h20);
    wr(A_FLAG, 32'h20);
    wr(A_RISE, 32'h20);
    set_pin(5, 1'b1, 5); rd(A_FLAG, v); chk("R3 both: rise sets", v, 32'h20);
    wr(A_FLAG, 32'h20);
    set_pin(5, 1'b0, 5); rd(A_FLAG, v); chk("R3 both: fall sets", v, 32'h20);
    wr(A_FLAG, 32'h20); wr(A_RISE, 0); wr(A_FALL, 0);
    pulse(5, 3, 5); rd(A_FLAG, v); chk("R3 neither enabled", v, 32'h0);
  endtask

  task automatic t_w1c_r4();
    logic [31:0] v;
    wr(A_RISE, 32'h6);
    pin_in[1] = 1'b1; pin_in[2] = 1'b1; wait_n(5);
    rd(A_FLAG, v); chk("R4 two flags set", v, 32'h6);
    wr(A_FLAG, 32'h0); rd(A_FLAG, v); chk("R4 zero write keeps flags", v, 32'h6);
    wr(A_FLAG, 32'h2); rd(A_FLAG, v); chk("R4 one bit cleared", v, 32'h4);
    wr(A_FLAG, 32'h4); rd(A_FLAG, v); chk("R4 last cleared", v, 32'h0);
    pin_in[1] = 1'b0; pin_in[2] = 1'b0; wait_n(5); wr(A_RISE, 0);
  endtask

  task automatic t_group_r5();
    wr(A_RISE, 32'h8000_0400);
    pulse(10, 2, 5);
    chk("R5 flag without enable gives no line", 32'(irq_line), 32'h0);
    wr(A_REQEN, 32'h0000_0400); #1;
    chk("R5 pin 10 drives line 1", 32'(irq_line), 32'h2);
    pulse(31, 2, 5);
    chk("R5 pin 31 without enable", 32'(irq_line), 32'h2);
    wr(A_REQEN, 32'h8000_0400); #1;
    chk("R5 pin 31 drives line 3", 32'(irq_line), 32'hA);
    wr(A_FLAG, 32'h8000_0000); #1;
    chk("R5 line 3 drops after clear", 32'(irq_line), 32'h2);
  endtask

  task automatic t_dma_r6();
    logic [31:0] v;
    wr(A_RSEL, 32'h0000_0400); #1;
    chk("R6 select moves request off line", 32'(irq_line), 32'h0);
    chk("R6 dma request raised", 32'(dma_req), 32'h400);
    dma_ack[10] = 1'b1; wait_n(1); dma_ack[10] = 1'b0;
    rd(A_FLAG, v); chk("R6 ack clears flag", v, 32'h0);
    chk("R6 dma request dropped", 32'(dma_req), 32'h0);
    wr(A_RSEL, 0); wr(A_REQEN, 0); wr(A_RISE, 0);
  endtask

  task automatic t_bypass_r7();
    logic [31:0] v;
    wr(A_RISE, 32'h1000); wr(A_LIM + 8'd48, 32'hF);
    pulse(12, 1, 5); rd(A_FLAG, v); chk("R7 one-clock pulse passes bypass", v, 32'h1000);
    wr(A_FLAG, 32'h1000); wr(A_RISE, 0);
  endtask

  task automatic t_filter_r8();
    logic [31:0] v;
    wr(A_RISE, 32'h4000); wr(A_FEN, 32'h4000); wr(A_LIM + 8'd56, 32'h3); wr(A_PRE, 0);
    pulse(14, 3, 8); rd(A_FLAG, v); chk("R8 three-tick glitch blocked", v, 32'h0);
    pulse(14, 10, 10); rd(A_FLAG, v); chk("R8 long pulse passes", v, 32'h4000);
    wr(A_FLAG, 32'h4000);
    wr(A_LIM + 8'd56, 32'h1); wr(A_PRE, 32'h3);
    pulse(14, 4, 12); rd(A_FLAG, v); chk("R8 prescaled short pulse blocked", v, 32'h0);
    pulse(14, 20, 16); rd(A_FLAG, v); chk("R8 prescaled long pulse passes", v, 32'h4000);
    wr(A_FLAG, 32'h4000); wr(A_FEN, 0); wr(A_RISE, 0); wr(A_PRE, 0);
  endtask

  task automatic t_race_r9();
    logic [31:0] v;
    wr(A_RISE, 32'h10_0000); wr(A_FALL, 32'h10_0000);
    set_pin(20, 1'b1, 5); rd(A_FLAG, v); chk("R9 flag set before race", v, 32'h10_0000);
    pin_in[20] = 1'b0;
    wait_n(2);
    wr(A_FLAG, 32'h10_0000);
    rd(A_FLAG, v); chk("R9 edge beats clear in same cycle", v, 32'h10_0000);
    wr(A_FLAG, 32'h10_0000);
    rd(A_FLAG, v); chk("R9 later clear works", v, 32'h0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset_r1();
    t_readback_r10();
    t_rise_r2();
    t_fall_both_r3();
    t_w1c_r4();
    t_group_r5();
    t_dma_r6();
    t_bypass_r7();
    t_filter_r8();
    t_race_r9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule